// File: doc/BRIEF.md
# Serial Receive Path with Gated FIFO Write

This block is the receive half of an asynchronous serial port. It watches an oversampled receive line, finds the start of each frame and shifts the data bits in, least significant bit first. It then takes an optional parity bit and one or two stop bits. When a frame completes, the block decides whether the byte may enter a small receive FIFO. Software, or a consumer next to the block, drains the FIFO through a first-word-fall-through read port.

Four status conditions are tracked: FIFO filled to a programmable trigger level, data waiting after a long idle, receive error (framing or parity), and break. Each condition has its own enable. The four enabled conditions are merged in pairs onto two request lines. The first line carries the FIFO-level and data-waiting conditions. The second carries the error and break conditions. The sample-rate strobe comes from an external divider. The line rate is one bit every `OSR` strobes.

Top module: `serial_rx_gate`

## Requirements
- R1: After reset the FIFO is empty (fill level 0, `rd_valid` low), all five flags are 0 and both request outputs are 0.
- R2: A frame starts on the first strobe where the synchronised line is low in idle. If the majority of the three mid-bit samples of the start bit (strobes 7, 8 and 9 after the edge, with OSR 16) is 1, the start is rejected and no byte or flag results.
- R3: Data bits are taken LSB first. With `cfg_len7`=0 eight bits are received. With `cfg_len7`=1 seven bits are received and appear on `rd_data[6:0]` with bit 7 read as 0.
- R4: With parity enabled, the expected parity bit is the XOR of the data bits, inverted when `cfg_par_odd`=1. A mismatch sets `flag_perr` and `flag_err`, and the byte is still stored.
- R5: A frame whose first stop bit is 0 sets `flag_err` and is not stored. With `cfg_stop2`=1 the second stop bit is not checked, and a frame with a 0 there is stored without error.
- R6: After a framing or parity error, reception continues and the next good frame is stored.
- R7: When the FIFO holds `DEPTH` bytes, a further good frame is discarded and the stored bytes are unchanged and read back in arrival order.
- R8: A frame that is entirely 0, including parity (if enabled) and stop bit, sets `flag_brk`. The flag stays set until `clr_brk`, and no byte is stored while it is set.
- R9: `flag_full` is set while the fill level is at least `trig_lvl`. A `clr_full` pulse clears it only once the level is below the trigger.
- R10: `flag_ready` is set when the receiver has been idle for `IDLE_BITS` bit times with the FIFO non-empty. It is not set earlier, and it stays set until `clr_ready`.
- R11: `irq_data` is high exactly when (`flag_full` and `ie_full`) or (`flag_ready` and `ie_ready`). `irq_status` is high exactly when (`flag_err` and `ie_err`) or (`flag_brk` and `ie_brk`).
- R12: A `clr_err` pulse clears both `flag_err` and `flag_perr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| os_tick | input | 1 | Oversampling strobe, OSR per bit |
| rx_in | input | 1 | Serial receive line, idle high |
| cfg_par_en | input | 1 | Parity bit present |
| cfg_par_odd | input | 1 | 1 odd parity, 0 even |
| cfg_stop2 | input | 1 | Two stop bits |
| cfg_len7 | input | 1 | 7 data bits instead of 8 |
| trig_lvl | input | LW | FIFO level for the full flag |
| rd_en | input | 1 | Pop the head byte |
| rd_data | output | 8 | Head byte of the FIFO |
| rd_valid | output | 1 | FIFO not empty |
| fill_lvl | output | LW | Bytes held in the FIFO |
| ie_full | input | 1 | Enable for the level condition |
| ie_ready | input | 1 | Enable for the idle-data condition |
| ie_err | input | 1 | Enable for the error condition |
| ie_brk | input | 1 | Enable for the break condition |
| clr_full | input | 1 | Clear strobe for flag_full |
| clr_ready | input | 1 | Clear strobe for flag_ready |
| clr_err | input | 1 | Clear strobe for flag_err and flag_perr |
| clr_brk | input | 1 | Clear strobe for flag_brk |
| flag_full | output | 1 | FIFO level reached trigger |
| flag_ready | output | 1 | Data waiting after idle |
| flag_err | output | 1 | Framing or parity error seen |
| flag_perr | output | 1 | Parity error seen |
| flag_brk | output | 1 | Break frame seen |
| irq_data | output | 1 | Shared level/idle-data request |
| irq_status | output | 1 | Shared error/break request |

## Verification
The hardest case to reach from the ports is the interplay around a break. The all-zero frame ends with a low stop bit. The receiver returns to idle while the line is still low, so it must reject the false start it then detects. Later frames must then be refused by the sticky break flag rather than by the stop check. The bench drives a full-length low frame, then a well-formed frame while the flag is still set, and checks that the fill level does not move. It then clears the flag and repeats the good frame to show storage resumes. Overflow is reached by sending DEPTH frames without reading and then one more.

// File: rtl/rxg_pkg.sv
package rxg_pkg;
  typedef enum logic [2:0] {
    S_IDLE, S_START, S_DATA, S_PAR, S_STOP1, S_STOP2
  } rx_state_e;

  function automatic logic maj3(input logic a, input logic b, input logic c);
    return (a & b) | (a & c) | (b & c);
  endfunction

  // parity bit a transmitter would have sent for this byte
  function automatic logic exp_parity(input logic [7:0] d, input logic len7,
                                      input logic odd);
    logic [7:0] m;
    m = len7 ? (d & 8'h7f) : d;
    return (^m) ^ odd;
  endfunction

  // shift register fills from the top; 7-bit frames sit one place high
  function automatic logic [7:0] align_data(input logic [7:0] sh, input logic len7);
    return len7 ? {1'b0, sh[7:1]} : sh;
  endfunction
endpackage

// File: rtl/rxg_framer.sv
module rxg_framer import rxg_pkg::*; #(
  parameter int OSR = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       rx,
  input  logic       cfg_par_en,
  input  logic       cfg_par_odd,
  input  logic       cfg_stop2,
  input  logic       cfg_len7,
  output logic       busy,
  output logic       frame_done,
  output logic       glitch,
  output logic [7:0] f_data,
  output logic       f_stop_ok,
  output logic       f_par_err,
  output logic       f_all_zero
);
  localparam int CW  = $clog2(OSR);
  localparam int MID = OSR / 2;

  rx_state_e      state;
  logic [CW-1:0]  os_cnt;
  logic [2:0]     bit_idx;
  logic [7:0]     sh;
  logic [1:0]     smp;
  logic           par_bit, stop_bit;
  logic           bitv, decide, bit_end;
  logic [2:0]     last_idx;

  assign bitv     = maj3(smp[0], smp[1], rx);
  assign decide   = (os_cnt == CW'(MID + 1));
  assign bit_end  = (os_cnt == CW'(OSR - 1));
  assign last_idx = cfg_len7 ? 3'd6 : 3'd7;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= S_IDLE;
      os_cnt     <= '0;
      bit_idx    <= '0;
      sh         <= '0;
      smp        <= '0;
      par_bit    <= 1'b0;
      stop_bit   <= 1'b1;
      frame_done <= 1'b0;
      glitch     <= 1'b0;
    end else begin
      frame_done <= 1'b0;
      glitch     <= 1'b0;
      if (tick) begin
        if (state == S_IDLE) begin
          if (!rx) begin
            state  <= S_START;
            os_cnt <= CW'(1);
          end
        end else begin
          os_cnt <= bit_end ? '0 : os_cnt + 1'b1;
          if (os_cnt == CW'(MID - 1)) smp[0] <= rx;
          if (os_cnt == CW'(MID))     smp[1] <= rx;
          case (state)
            S_START: begin
              if (decide && bitv) begin
                state  <= S_IDLE;
                glitch <= 1'b1;
              end else if (bit_end) begin
                state   <= S_DATA;
                bit_idx <= '0;
              end
            end
            S_DATA: begin
              if (decide) sh <= {bitv, sh[7:1]};
              if (bit_end) begin
                if (bit_idx == last_idx) state <= cfg_par_en ? S_PAR : S_STOP1;
                else bit_idx <= bit_idx + 1'b1;
              end
            end
            S_PAR: begin
              if (decide)  par_bit <= bitv;
              if (bit_end) state   <= S_STOP1;
            end
            S_STOP1: begin
              if (decide) begin
                stop_bit <= bitv;
                if (!cfg_stop2) begin
                  frame_done <= 1'b1;
                  state      <= S_IDLE;
                end
              end else if (bit_end) begin
                state <= S_STOP2;
              end
            end
            S_STOP2: begin
              if (decide) begin
                frame_done <= 1'b1;
                state      <= S_IDLE;
              end
            end
            default: state <= S_IDLE;
          endcase
        end
      end
    end
  end

  assign busy       = (state != S_IDLE);
  assign f_data     = align_data(sh, cfg_len7);
  assign f_stop_ok  = stop_bit;
  assign f_par_err  = cfg_par_en && (par_bit != exp_parity(f_data, cfg_len7, cfg_par_odd));
  assign f_all_zero = (f_data == 8'h00) && !(cfg_par_en && par_bit) && !stop_bit;
endmodule

// File: rtl/rxg_fifo.sv
module rxg_fifo #(
  parameter int DEPTH = 16,
  parameter int W     = 8,
  localparam int AW   = $clog2(DEPTH),
  localparam int LW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [W-1:0]  din,
  input  logic          pop,
  output logic [W-1:0]  dout,
  output logic [LW-1:0] level,
  output logic          full,
  output logic          empty
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic          do_push, do_pop;

  assign full    = (level == LW'(DEPTH));
  assign empty   = (level == '0);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign dout    = mem[rp];

  always_ff @(posedge clk) begin
    if (do_push) mem[wp] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp    <= '0;
      rp    <= '0;
      level <= '0;
    end else begin
      if (do_push) wp <= (wp == AW'(DEPTH - 1)) ? '0 : wp + 1'b1;
      if (do_pop)  rp <= (rp == AW'(DEPTH - 1)) ? '0 : rp + 1'b1;
      case ({do_push, do_pop})
        2'b10:   level <= level + 1'b1;
        2'b01:   level <= level - 1'b1;
        default: level <= level;
      endcase
    end
  end
endmodule

// File: rtl/rxg_idle_timer.sv
module rxg_idle_timer #(
  parameter int LIMIT = 240,
  localparam int TW   = $clog2(LIMIT + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic busy,
  output logic hit
);
  logic [TW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      hit <= 1'b0;
    end else begin
      hit <= !busy && tick && (cnt == TW'(LIMIT - 1));
      if (busy)                              cnt <= '0;
      else if (tick && cnt != TW'(LIMIT))    cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/serial_rx_gate.sv
module serial_rx_gate import rxg_pkg::*; #(
  parameter int OSR       = 16,
  parameter int DEPTH     = 16,
  parameter int IDLE_BITS = 15,
  localparam int LW       = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          os_tick,
  input  logic          rx_in,
  input  logic          cfg_par_en,
  input  logic          cfg_par_odd,
  input  logic          cfg_stop2,
  input  logic          cfg_len7,
  input  logic [LW-1:0] trig_lvl,
  input  logic          rd_en,
  output logic [7:0]    rd_data,
  output logic          rd_valid,
  output logic [LW-1:0] fill_lvl,
  input  logic          ie_full,
  input  logic          ie_ready,
  input  logic          ie_err,
  input  logic          ie_brk,
  input  logic          clr_full,
  input  logic          clr_ready,
  input  logic          clr_err,
  input  logic          clr_brk,
  output logic          flag_full,
  output logic          flag_ready,
  output logic          flag_err,
  output logic          flag_perr,
  output logic          flag_brk,
  output logic          irq_data,
  output logic          irq_status
);
  localparam int IDLE_TICKS = IDLE_BITS * OSR;

  logic       rx_s1, rx_s2;
  logic       busy, frame_done, glitch;
  logic [7:0] f_data;
  logic       f_stop_ok, f_par_err, f_all_zero;
  logic       push, fifo_full, fifo_empty, idle_hit;
  logic       bad_frame;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_s1 <= 1'b1;
      rx_s2 <= 1'b1;
    end else begin
      rx_s1 <= rx_in;
      rx_s2 <= rx_s1;
    end
  end

  rxg_framer #(.OSR(OSR)) u_framer (
    .clk, .rst_n, .tick(os_tick), .rx(rx_s2),
    .cfg_par_en, .cfg_par_odd, .cfg_stop2, .cfg_len7,
    .busy, .frame_done, .glitch, .f_data, .f_stop_ok, .f_par_err, .f_all_zero
  );

  // acceptance gate: good stop bit, room in the FIFO, break flag clear
  assign push      = frame_done && f_stop_ok && !fifo_full && !flag_brk;
  assign bad_frame = frame_done && (!f_stop_ok || f_par_err);

  rxg_fifo #(.DEPTH(DEPTH), .W(8)) u_fifo (
    .clk, .rst_n, .push, .din(f_data), .pop(rd_en),
    .dout(rd_data), .level(fill_lvl), .full(fifo_full), .empty(fifo_empty)
  );

  rxg_idle_timer #(.LIMIT(IDLE_TICKS)) u_idle (
    .clk, .rst_n, .tick(os_tick), .busy, .hit(idle_hit)
  );

  assign rd_valid = !fifo_empty;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_full  <= 1'b0;
      flag_ready <= 1'b0;
      flag_err   <= 1'b0;
      flag_perr  <= 1'b0;
      flag_brk   <= 1'b0;
    end else begin
      flag_full  <= (fill_lvl >= trig_lvl) | (flag_full & ~clr_full);
      flag_ready <= (idle_hit & ~fifo_empty) | (flag_ready & ~clr_ready);
      flag_err   <= bad_frame | (flag_err & ~clr_err);
      flag_perr  <= (frame_done & f_par_err) | (flag_perr & ~clr_err);
      flag_brk   <= (frame_done & f_all_zero) | (flag_brk & ~clr_brk);
    end
  end

  assign irq_data   = (flag_full & ie_full) | (flag_ready & ie_ready);
  assign irq_status = (flag_err & ie_err) | (flag_brk & ie_brk);
endmodule

// File: rtl/rxg_checker.sv
module rxg_checker #(
  parameter int DEPTH = 16,
  localparam int LW   = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          frame_done,
  input logic          f_stop_ok,
  input logic          glitch,
  input logic          busy,
  input logic          rd_en,
  input logic [LW-1:0] fill_lvl,
  input logic [LW-1:0] trig_lvl,
  input logic          flag_full,
  input logic          flag_err,
  input logic          flag_brk,
  input logic          clr_brk,
  input logic          ie_full,
  input logic          ie_ready,
  input logic          ie_err,
  input logic          ie_brk,
  input logic          irq_data,
  input logic          irq_status
);
  p_fill_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
    fill_lvl <= LW'(DEPTH));

  p_full_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_lvl == LW'(DEPTH) && !rd_en) |=> fill_lvl == LW'(DEPTH));

  p_glitch_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    glitch |-> !busy && !frame_done);

  p_bad_stop_err_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_done && !f_stop_ok) |=> flag_err);

  p_bad_stop_drop_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_done && !f_stop_ok && !rd_en) |=> fill_lvl == $past(fill_lvl));

  p_brk_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_brk && !clr_brk) |=> flag_brk);

  p_brk_no_store_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_brk && !rd_en) |=> fill_lvl <= $past(fill_lvl));

  p_trig_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_lvl >= trig_lvl) |=> flag_full);

  p_data_mask_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!ie_full && !ie_ready) |-> !irq_data);

  p_status_mask_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!ie_err && !ie_brk) |-> !irq_status);
endmodule

bind serial_rx_gate rxg_checker #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .frame_done(frame_done), .f_stop_ok(f_stop_ok),
  .glitch(glitch), .busy(busy), .rd_en(rd_en), .fill_lvl(fill_lvl),
  .trig_lvl(trig_lvl), .flag_full(flag_full), .flag_err(flag_err),
  .flag_brk(flag_brk), .clr_brk(clr_brk), .ie_full(ie_full),
  .ie_ready(ie_ready), .ie_err(ie_err), .ie_brk(ie_brk),
  .irq_data(irq_data), .irq_status(irq_status)
);

// File: tb/tb_serial_rx_gate.sv
module tb_serial_rx_gate;
  localparam int CLK_P = 10;
  localparam int OSR   = 16;
  localparam int DEPTH = 16;
  localparam int LW    = $clog2(DEPTH + 1);

  logic clk = 0, rst_n = 0, os_tick = 1, rx_in = 1;
  logic cfg_par_en = 0, cfg_par_odd = 0, cfg_stop2 = 0, cfg_len7 = 0;
  logic [LW-1:0] trig_lvl = LW'(DEPTH);
  logic rd_en = 0;
  logic [7:0] rd_data;
  logic rd_valid;
  logic [LW-1:0] fill_lvl;
  logic ie_full = 0, ie_ready = 0, ie_err = 0, ie_brk = 0;
  logic clr_full = 0, clr_ready = 0, clr_err = 0, clr_brk = 0;
  logic flag_full, flag_ready, flag_err, flag_perr, flag_brk, irq_data, irq_status;

  int n_chk = 0, n_fail = 0;

  always #(CLK_P/2) clk = ~clk;

  serial_rx_gate #(.OSR(OSR), .DEPTH(DEPTH), .IDLE_BITS(15)) dut (.*);

  task automatic chk(input bit ok, input string tag, input int act, input int exp_v);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp_v);
    end
  endtask

  task automatic hold_bit(input logic b);
    rx_in = b;
    repeat (OSR) @(negedge clk);
  endtask

  task automatic send_frame(input logic [7:0] d, input int nbits, input bit par_flip,
                            input bit stop1, input bit stop2v, input int gap);
    logic p;
    p = 1'b0;
    hold_bit(1'b0);
    for (int i = 0; i < nbits; i++) begin
      hold_bit(d[i]);
      p = p ^ d[i];
    end
    if (cfg_par_en) hold_bit(p ^ cfg_par_odd ^ par_flip);
    hold_bit(stop1);
    if (cfg_stop2) hold_bit(stop2v);
    rx_in = 1'b1;
    repeat (gap * OSR) @(negedge clk);
  endtask

  task automatic good(input logic [7:0] d);
    send_frame(d, cfg_len7 ? 7 : 8, 0, 1, 1, 2);
  endtask

  task automatic pop_chk(input logic [7:0] exp_d, input string tag);
    chk(rd_valid === 1'b1, tag, rd_valid, 1);
    chk(rd_data === exp_d, tag, rd_data, exp_d);
    rd_en = 1; @(negedge clk); rd_en = 0; @(negedge clk);
  endtask

  task automatic pulse(ref logic s);
    s = 1; @(negedge clk); s = 0; @(negedge clk);
  endtask

  task automatic drain();
    while (rd_valid) begin rd_en = 1; @(negedge clk); rd_en = 0; @(negedge clk); end
  endtask

  task automatic t_reset();
    chk(fill_lvl == 0 && rd_valid == 0, "R1 fifo", fill_lvl, 0);
    chk({flag_full, flag_ready, flag_err, flag_perr, flag_brk} == 5'b0, "R1 flags",
        {flag_full, flag_ready, flag_err, flag_perr, flag_brk}, 0);
    chk({irq_data, irq_status} == 2'b0, "R1 irq", {irq_data, irq_status}, 0);
  endtask

  task automatic t_glitch();
    rx_in = 0; repeat (4) @(negedge clk); rx_in = 1;
    repeat (3 * OSR) @(negedge clk);
    chk(fill_lvl == 0 && flag_err == 0, "R2 glitch rejected", fill_lvl, 0);
  endtask

  task automatic t_lsb();
    good(8'hA5); good(8'h3C);
    chk(fill_lvl == 2, "R3 two stored", fill_lvl, 2);
    pop_chk(8'hA5, "R3 lsb first A5");
    pop_chk(8'h3C, "R3 lsb first 3C");
    cfg_len7 = 1;
    send_frame(8'hD3, 7, 0, 1, 1, 2);
    pop_chk(8'h53, "R3 seven bit");
    cfg_len7 = 0;
  endtask

  task automatic t_parity();
    cfg_par_en = 1; cfg_par_odd = 0;
    good(8'h31);
    chk(flag_perr == 0 && flag_err == 0, "R4 even ok", flag_perr, 0);
    send_frame(8'h31, 8, 1, 1, 1, 2);
    chk(flag_perr == 1 && flag_err == 1, "R4 mismatch flags", {flag_perr, flag_err}, 3);
    chk(fill_lvl == 2, "R4 stored anyway", fill_lvl, 2);
    pulse(clr_err);
    chk(flag_perr == 0 && flag_err == 0, "R12 clear", {flag_perr, flag_err}, 0);
    cfg_par_odd = 1;
    good(8'h31);
    chk(flag_perr == 0 && fill_lvl == 3, "R4 odd ok", {flag_perr, fill_lvl}, 3);
    cfg_par_en = 0; cfg_par_odd = 0;
    drain();
  endtask

  task automatic t_stop();
    send_frame(8'h11, 8, 0, 0, 1, 2);
    chk(flag_err == 1, "R5 framing err", flag_err, 1);
    chk(fill_lvl == 0, "R5 not stored", fill_lvl, 0);
    ie_err = 1; @(negedge clk);
    chk(irq_status == 1, "R11 err request", irq_status, 1);
    ie_err = 0; @(negedge clk);
    chk(irq_status == 0, "R11 err masked", irq_status, 0);
    good(8'h66);
    pop_chk(8'h66, "R6 continues");
    pulse(clr_err);
    cfg_stop2 = 1;
    send_frame(8'h5A, 8, 0, 1, 0, 2);
    chk(flag_err == 0, "R5 second stop unchecked", flag_err, 0);
    pop_chk(8'h5A, "R5 stop2 stored");
    cfg_stop2 = 0;
  endtask

  task automatic t_full();
    for (int i = 0; i < DEPTH; i++) good(8'(i + 8'h20));
    chk(fill_lvl == DEPTH, "R7 full", fill_lvl, DEPTH);
    good(8'hEE);
    chk(fill_lvl == DEPTH, "R7 overflow dropped", fill_lvl, DEPTH);
    for (int i = 0; i < DEPTH; i++) pop_chk(8'(i + 8'h20), "R7 order");
    chk(rd_valid == 0, "R7 drained", rd_valid, 0);
    pulse(clr_full);
  endtask

  task automatic t_break();
    send_frame(8'h00, 8, 0, 0, 0, 2);
    chk(flag_brk == 1 && flag_err == 1, "R8 break set", {flag_brk, flag_err}, 3);
    ie_brk = 1; @(negedge clk);
    chk(irq_status == 1, "R11 brk request", irq_status, 1);
    good(8'h42);
    chk(fill_lvl == 0 && flag_brk == 1, "R8 blocked and sticky", fill_lvl, 0);
    pulse(clr_brk); pulse(clr_err);
    chk(flag_brk == 0 && irq_status == 0, "R8 cleared", flag_brk, 0);
    ie_brk = 0;
    good(8'h42);
    pop_chk(8'h42, "R8 resumes");
  endtask

  task automatic t_trig();
    trig_lvl = 2; pulse(clr_full);
    good(8'h01);
    chk(flag_full == 0, "R9 below trig", flag_full, 0);
    good(8'h02);
    chk(flag_full == 1, "R9 at trig", flag_full, 1);
    ie_full = 1; @(negedge clk);
    chk(irq_data == 1, "R11 level request", irq_data, 1);
    pulse(clr_full);
    chk(flag_full == 1, "R9 clear ignored at trig", flag_full, 1);
    pop_chk(8'h01, "R9 pop");
    pulse(clr_full);
    chk(flag_full == 0 && irq_data == 0, "R9 clear below trig", flag_full, 0);
    ie_full = 0; drain(); trig_lvl = LW'(DEPTH);
  endtask

  task automatic t_ready();
    repeat (16 * OSR) @(negedge clk);
    pulse(clr_ready); pulse(clr_full);
    send_frame(8'h77, 8, 0, 1, 1, 0);
    repeat (14 * OSR) @(negedge clk);
    chk(flag_ready == 0, "R10 not before idle", flag_ready, 0);
    repeat (2 * OSR) @(negedge clk);
    chk(flag_ready == 1, "R10 after idle", flag_ready, 1);
    chk(irq_data == 0, "R11 ready masked", irq_data, 0);
    ie_ready = 1; @(negedge clk);
    chk(irq_data == 1, "R11 ready request", irq_data, 1);
    pop_chk(8'h77, "R10 byte");
    chk(flag_ready == 1, "R10 stays set", flag_ready, 1);
    pulse(clr_ready);
    chk(flag_ready == 0 && irq_data == 0, "R10 cleared", flag_ready, 0);
    ie_ready = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_glitch();
    t_lsb();
    t_parity();
    t_stop();
    t_full();
    t_break();
    t_trig();
    t_ready();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule